// File: doc/BRIEF.md
# Cycle Pattern Sequencer

This block plays back a stored sequence of 16-bit words, presenting one word per bunch-clock cycle. Each bit of the output can be raised at any chosen cycle of a machine turn. That makes the output usable as local triggers, broadcast commands, veto masks or a 3-bit calibration request. The words sit in an internal synchronous RAM whose depth is a parameter. The default depth is small, for simulation; a full-size build would use 2^20 words, about 26 ms at the bunch-clock rate.

A small register bus has four registers: control/status, start-address preset, memory data and fixed value. Through them software fills the memory, reads it back, presets the start address and chooses how playback starts. Playback starts from one of three sources: an orbit pulse, a pre-trigger warning pulse or a software write. It runs once or loops forever. Whenever no memory word is being played, the output shows a programmable fixed value.

Top module: `pattern_sequencer`

## Requirements
- R1: After reset, `pat_out` is 0, `running` is 0 and reading the control register (bus address 0) returns 0.
- R2: With control op field bits [1:0] = 01 (load), each write to bus address 2 stores a word at the address counter, then advances the counter. With op = 10 (read-back), bus address 2 shows the word at the counter, and a `bus_rd` pulse there advances the counter. Writing the op field, or writing bus address 1, loads the counter from the preset value (bits [AW-1:0]). The counter wraps from DEPTH-1 to 0.
- R3: When no word is being played, `pat_out` equals the fixed-value register (bus address 3), one cycle after that register is written.
- R4: Op = 11 arms the sequencer. The start source is control bits [3:2]: 00 orbit, 01 pre-pulse, 10 software, 11 none. A software start is a control write with bit 8 set, and that bit is not stored. A start from a source that is not selected is ignored.
- R5: An orbit or pre-pulse start that is high at clock edge k sets `running` after edge k. The word at the preset address appears on `pat_out` after edge k+2, and one following word appears per cycle after that. A software start written at edge k sets `running` after edge k+1, and its first word appears after edge k+3.
- R6: In one-shot mode (control bit 4 = 0), playback ends once the word at DEPTH-1 has been read. `running` falls one cycle before that last word is shown, and `pat_out` returns to the fixed value on the cycle after it. The sequencer then ignores starts until the control register is written again.
- R7: In continuous mode (control bit 4 = 1), playback goes from address DEPTH-1 to address 0 and keeps running.
- R8: A start event that arrives while a sequence is running is ignored.
- R9: While running, bus writes to the memory data register leave the memory unchanged.
- R10: With control bit 5 = 0, `pat_out` shows the fixed value even while running. With bit 5 = 1, it shows the played words.
- R11: Bit 15 of the control register reads as 1 exactly while the sequencer is running. A write with op = 00 stops playback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| orbit_i | input | 1 | Orbit pulse, one cycle high |
| prepulse_i | input | 1 | Pre-trigger warning pulse, one cycle high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances counter in read-back) |
| bus_addr | input | 2 | Register select: 0 control, 1 preset, 2 data, 3 fixed |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for the selected register (combinational) |
| pat_out | output | WIDTH | Registered pattern output |
| running | output | 1 | High while playback is running |

## Verification
Each result has its own latency. A pin start sets `running` one edge after the start pulse and shows the first word two edges later. A software start adds one cycle to both. The fixed value reaches the output one edge after it is written. In one-shot mode, the output falls back one edge after the last word. The bench drives inputs 1 ns after a rising edge, steps exactly the number of edges that R5, R6 and R3 give, and samples between edges. The bench keeps its own copy of the memory contents and predicts every played word from it. Each ignored start or write is checked afterwards, either by its effect on the next output words or by a full read-back of the memory.

// File: rtl/pattern_sequencer.sv
module pattern_sequencer #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             orbit_i,
  input  logic             prepulse_i,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  output logic [WIDTH-1:0] pat_out,
  output logic             running
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_READ, S_ARMED, S_RUN, S_DONE} st_t;

  st_t              st;
  logic [1:0]       op_q, src_q;
  logic             cont_q, sel_q, sw_go;
  logic [AW-1:0]    shadow_q, addr_q;
  logic [WIDTH-1:0] fixed_q, rd_q, out_q;
  logic             v1_q;
  logic [WIDTH-1:0] mem [DEPTH];

  wire wr_csr = bus_wr && bus_addr == 2'd0;
  wire wr_shd = bus_wr && bus_addr == 2'd1;
  wire wr_dat = bus_wr && bus_addr == 2'd2;
  wire rd_dat = bus_rd && bus_addr == 2'd2;
  wire wr_fix = bus_wr && bus_addr == 2'd3;

  wire start_evt = (st == S_ARMED) &&
                   ((src_q == 2'd0 && orbit_i) ||
                    (src_q == 2'd1 && prepulse_i) ||
                    (src_q == 2'd2 && sw_go));
  wire           at_last  = (addr_q == LAST);
  wire [AW-1:0]  addr_inc = at_last ? '0 : addr_q + 1'b1;

  assign running = (st == S_RUN);
  assign pat_out = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= '0;
      src_q    <= '0;
      cont_q   <= 1'b0;
      sel_q    <= 1'b0;
      sw_go    <= 1'b0;
      shadow_q <= '0;
      addr_q   <= '0;
      fixed_q  <= '0;
    end else begin
      sw_go <= wr_csr && bus_wdata[8];
      if (wr_csr) begin
        op_q   <= bus_wdata[1:0];
        src_q  <= bus_wdata[3:2];
        cont_q <= bus_wdata[4];
        sel_q  <= bus_wdata[5];
        addr_q <= shadow_q;
        case (bus_wdata[1:0])
          2'd0:    st <= S_IDLE;
          2'd1:    st <= S_LOAD;
          2'd2:    st <= S_READ;
          default: st <= S_ARMED;
        endcase
      end else begin
        case (st)
          S_ARMED: if (start_evt) begin
            st     <= S_RUN;
            addr_q <= shadow_q;
          end
          S_RUN: begin
            addr_q <= addr_inc;
            if (at_last && !cont_q) st <= S_DONE;
          end
          S_LOAD:  if (wr_dat) addr_q <= addr_inc;
          S_READ:  if (rd_dat) addr_q <= addr_inc;
          default: ;
        endcase
      end
      if (wr_shd) begin
        shadow_q <= bus_wdata[AW-1:0];
        if (st != S_RUN && st != S_ARMED) addr_q <= bus_wdata[AW-1:0];
      end
      if (wr_fix) fixed_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_dat && st == S_LOAD && !wr_csr) mem[addr_q] <= bus_wdata;
    rd_q <= mem[addr_q];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q  <= 1'b0;
      out_q <= '0;
    end else begin
      v1_q  <= running;
      out_q <= (v1_q && sel_q) ? rd_q : fixed_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: begin
        bus_rdata[1:0] = op_q;
        bus_rdata[3:2] = src_q;
        bus_rdata[4]   = cont_q;
        bus_rdata[5]   = sel_q;
        bus_rdata[15]  = running;
      end
      2'd1:    bus_rdata = WIDTH'(shadow_q);
      2'd2:    bus_rdata = rd_q;
      default: bus_rdata = fixed_q;
    endcase
  end

  a_r5_start_from_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !wr_csr) |=> (running && addr_q == $past(shadow_q)));

  a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (running && at_last && !cont_q && !wr_csr) |=> !running);

  a_r7_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running)) |->
      (addr_q == (($past(addr_q) == LAST) ? '0 : $past(addr_q) + 1'b1)));

  a_r3_fixed_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !$past(running)) |=> (pat_out == $past(fixed_q)));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wr_csr && !at_last) |=> running);
endmodule

// File: tb/tb_pattern_sequencer.sv
module tb_pattern_sequencer;
  localparam int W = 16;
  localparam int D = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         orbit_i = 1'b0, prepulse_i = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata, pat_out;
  logic         running;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] model [D];
  localparam logic [W-1:0] FIX = 16'h5A5A;

  pattern_sequencer #(.WIDTH(W), .DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .orbit_i(orbit_i), .prepulse_i(prepulse_i),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pat_out(pat_out),
    .running(running));

  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_word(output logic [W-1:0] v);
    bus_addr = 2'd2;
    tick();
    v = bus_rdata;
    bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    bus_addr = 2'd0;
    #1;
    chk("R1 pat_out", pat_out, '0);
    chk("R1 running", {15'd0, running}, '0);
    chk("R1 csr", bus_rdata, '0);
  endtask

  task automatic t_load();
    logic [W-1:0] v;
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h0001);
    for (int i = 0; i < D; i++) begin
      model[i] = 16'h8000 + W'(i) * 16'h0103;
      wr(2'd2, model[i]);
    end
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0002);
    for (int i = 5; i < 9; i++) begin
      rd_word(v);
      chk("R2 readback", v, model[i]);
    end
  endtask

  task automatic t_fixed();
    wr(2'd0, 16'h0020);
    wr(2'd3, FIX);
    tick();
    chk("R3 fixed value", pat_out, FIX);
  endtask

  task automatic t_oneshot_orbit();
    wr(2'd1, 16'd60);
    wr(2'd0, 16'h0023);
    prepulse_i = 1'b1; tick(); prepulse_i = 1'b0;
    tick();
    chk("R4 unselected source", {15'd0, running}, '0);
    chk("R4 output stays fixed", pat_out, FIX);
    orbit_i = 1'b1; tick(); orbit_i = 1'b0;
    chk("R5 running after orbit", {15'd0, running}, 16'd1);
    bus_addr = 2'd0; #0.1;
    chk("R11 status bit", {15'd0, bus_rdata[15]}, 16'd1);
    tick(); tick();
    chk("R5 first word", pat_out, model[60]);
    tick(); chk("R5 second word", pat_out, model[61]);
    tick(); chk("R5 third word", pat_out, model[62]);
    tick(); chk("R6 last word", pat_out, model[63]);
    chk("R6 running low", {15'd0, running}, '0);
    tick(); chk("R6 back to fixed", pat_out, FIX);
    orbit_i = 1'b1; tick(); orbit_i = 1'b0;
    tick(); tick();
    chk("R6 no restart when done", pat_out, FIX);
    chk("R6 not running", {15'd0, running}, '0);
  endtask

  task automatic t_cont_prepulse();
    logic [W-1:0] v;
    int bad;
    wr(2'd1, 16'd62);
    wr(2'd0, 16'h0037);
    prepulse_i = 1'b1; tick(); prepulse_i = 1'b0;
    tick(); tick();
    chk("R7 word 62", pat_out, model[62]);
    prepulse_i = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 16'hDEAD;
    tick();
    prepulse_i = 1'b0; bus_wr = 1'b0;
    chk("R7 word 63", pat_out, model[63]);
    tick(); chk("R7 wrap to 0", pat_out, model[0]);
    tick(); chk("R8 restart ignored", pat_out, model[1]);
    tick(); chk("R8 still playing", pat_out, model[2]);
    wr(2'd0, 16'h0020);
    chk("R11 stop", {15'd0, running}, '0);
    tick(); tick();
    chk("R11 fixed after stop", pat_out, FIX);
    wr(2'd1, 16'd0);
    wr(2'd0, 16'h0002);
    bad = 0;
    for (int i = 0; i < D; i++) begin
      rd_word(v);
      if (v !== model[i]) bad++;
    end
    chk("R9 memory unchanged after run write", W'(bad), '0);
  endtask

  task automatic t_software();
    wr(2'd1, 16'd10);
    wr(2'd0, 16'h0123);
    tick(); tick();
    chk("R4 go bit with orbit source", {15'd0, running}, '0);
    wr(2'd0, 16'h012B);
    chk("R5 sw not yet running", {15'd0, running}, '0);
    tick();
    chk("R5 sw running", {15'd0, running}, 16'd1);
    tick(); tick();
    chk("R5 sw first word", pat_out, model[10]);
    tick(); chk("R5 sw next word", pat_out, model[11]);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_sel_fixed();
    wr(2'd1, 16'd20);
    wr(2'd0, 16'h011B);
    tick(); tick(); tick();
    chk("R10 running with select 0", {15'd0, running}, 16'd1);
    chk("R10 fixed while running", pat_out, FIX);
    tick();
    chk("R10 fixed next cycle", pat_out, FIX);
    wr(2'd0, 16'h0000);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_fixed();
    t_oneshot_orbit();
    t_cont_prepulse();
    t_software();
    t_sel_fixed();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule